// File: doc/BRIEF.md
# Dependence-Chain FIFO Issue Scheduler

This block takes the place of a fully associative issue window. Renamed instructions arrive one per cycle. A dedicated steering stage sends each one into one of several small in-order queues. Placement follows a dependence heuristic, so that a chain of dependent instructions lines up in a single queue. Wakeup and select look only at the oldest entry of each queue. This removes the window-wide tag comparison from the scheduling critical path.

The steering stage consults a table indexed by physical register. The table records whether a register's producer is still waiting in a queue and, if so, which queue holds it. It also compares against each queue's tail entry to learn whether the producer is the last instruction in that queue. When an instruction is granted, its destination entry is erased. Later consumers then treat the value as coming from the register file. A per-register ready vector from writeback gates the issue of each queue head. A global limit caps how many heads may be granted in one cycle.

Top module: `dep_steer_sched`

## Requirements
- R1: Out of reset, no issue output is asserted, `in_rdy` is high and every queue is empty.
- R2: An instruction accepted at clock edge N is written into its queue at edge N+1. If its sources are ready, its `iss_vld` bit is high during the cycle between edges N+1 and N+2.
- R3: An instruction with no source whose producer is still queued goes to the lowest-numbered empty queue.
- R4: An instruction with one source whose producer is still queued goes to that producer's queue when the producer is the queue's tail and the queue is not full. Otherwise it goes to the lowest-numbered empty queue.
- R5: With both sources pending, the first source (`in_s0`) is tried first under the R4 rule. The second source (`in_s1`) is tried only when the first gives no queue. If neither gives a queue, the instruction goes to the lowest-numbered empty queue.
- R6: When no queue qualifies and none is empty, the instruction stays in the steering stage and `in_rdy` stays low. The instruction is placed as soon as a queue frees.
- R7: Only queue heads may issue. A head issues when each enabled source has its `reg_rdy` bit set. An entry behind a blocked head waits, even if its own operands are ready.
- R8: At most `ISSUE_W` heads are granted per cycle. Lower queue numbers have priority. `iss_vld[f]` marks a grant from queue f, and `iss_id[f*ID_W +: ID_W]` carries that entry's identifier.
- R9: When a producer issues, its table entry is erased. A later consumer of that register is then steered as if the operand were in the register file, even if the producer's old queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Incoming renamed instruction is valid |
| in_rdy | output | 1 | Steering stage can take an instruction this cycle |
| in_id | input | ID_W | Instruction identifier |
| in_dst_en | input | 1 | Instruction writes a destination register |
| in_dst | input | PTAG_W | Destination physical tag |
| in_s0_en | input | 1 | First source used |
| in_s0 | input | PTAG_W | First source physical tag |
| in_s1_en | input | 1 | Second source used |
| in_s1 | input | PTAG_W | Second source physical tag |
| reg_rdy | input | 2**PTAG_W | Per-register value-available bits from writeback |
| iss_vld | output | NFIFO | Per-queue issue grant |
| iss_id | output | NFIFO*ID_W | Identifier of each queue's head |

## Verification
Every cycle, the embedded properties check three things: the issue limit, that no queue overflows or underflows, and that a stalled steering stage holds its instruction unchanged. They also check that each issued destination leaves the producer table on the following cycle. Only the directed scenarios can show where each instruction was placed: the left-then-right dependence choice, the fallback to the lowest empty queue, and the effect of an erased producer entry. These scenarios observe which queue each identifier issues from, against a scoreboard of expected queue and identifier pairs. The scenarios also show in-order blocking behind a waiting head and the two-stage latency from acceptance to issue.

// File: rtl/dsched_pkg.sv
package dsched_pkg;
  parameter int PTAG_W = 5;
  parameter int ID_W   = 6;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              dst_en;
    logic [PTAG_W-1:0] dst;
    logic              s0_en;
    logic [PTAG_W-1:0] s0;
    logic              s1_en;
    logic [PTAG_W-1:0] s1;
  } sinst_t;
endpackage

// File: rtl/dsched_rst_sync.sv
module dsched_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/dsched_fifo.sv
module dsched_fifo
  import dsched_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  sinst_t                     din,
  input  logic                       pop,
  output sinst_t                     head,
  output logic                       hvld,
  output logic [$clog2(DEPTH+1)-1:0] cnt
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  sinst_t          mem [DEPTH];
  logic [PW-1:0]   rp, wp, rp_n, wp_n;
  logic [CW-1:0]   cnt_n;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rp_n  = pop  ? bump(rp) : rp;
    wp_n  = push ? bump(wp) : wp;
    cnt_n = cnt + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      rp  <= rp_n;
      wp  <= wp_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign head = mem[rp];
  assign hvld = (cnt != '0);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt != CW'(DEPTH)));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
endmodule

// File: rtl/dsched_steer.sv
module dsched_steer #(
  parameter int NFIFO = 4
) (
  input  logic                     l_hit,
  input  logic [$clog2(NFIFO)-1:0] l_fifo,
  input  logic                     r_hit,
  input  logic [$clog2(NFIFO)-1:0] r_fifo,
  input  logic [NFIFO-1:0]         empty,
  input  logic [NFIFO-1:0]         full,
  output logic                     ok,
  output logic [$clog2(NFIFO)-1:0] tgt
);
  localparam int FW = $clog2(NFIFO);

  always_comb begin
    ok  = 1'b0;
    tgt = '0;
    for (int i = NFIFO - 1; i >= 0; i--) begin
      if (empty[i]) begin
        ok  = 1'b1;
        tgt = FW'(i);
      end
    end
    if (r_hit && !full[r_fifo]) begin
      ok  = 1'b1;
      tgt = r_fifo;
    end
    if (l_hit && !full[l_fifo]) begin
      ok  = 1'b1;
      tgt = l_fifo;
    end
  end
endmodule

// File: rtl/dsched_arb.sv
module dsched_arb #(
  parameter int N     = 4,
  parameter int LIMIT = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] used;

  always_comb begin
    gnt  = '0;
    used = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (used < CW'(LIMIT))) begin
        gnt[i] = 1'b1;
        used   = used + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dep_steer_sched.sv
module dep_steer_sched
  import dsched_pkg::*;
#(
  parameter int NFIFO   = 4,
  parameter int DEPTH   = 4,
  parameter int ISSUE_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_vld,
  output logic                  in_rdy,
  input  logic [ID_W-1:0]       in_id,
  input  logic                  in_dst_en,
  input  logic [PTAG_W-1:0]     in_dst,
  input  logic                  in_s0_en,
  input  logic [PTAG_W-1:0]     in_s0,
  input  logic                  in_s1_en,
  input  logic [PTAG_W-1:0]     in_s1,
  input  logic [2**PTAG_W-1:0]  reg_rdy,
  output logic [NFIFO-1:0]      iss_vld,
  output logic [NFIFO*ID_W-1:0] iss_id
);
  localparam int NPREG = 2 ** PTAG_W;
  localparam int FW    = $clog2(NFIFO);
  localparam int CW    = $clog2(DEPTH + 1);

  logic rst_q_n;
  dsched_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_q_n(rst_q_n));

  // Steering stage register
  sinst_t stg, stg_n, in_bus;
  logic   stg_vld, stg_vld_n;

  // Producer table and per-queue tail record
  logic [NPREG-1:0]  pend, pend_n;
  logic [FW-1:0]     pfifo    [NPREG];
  logic [PTAG_W-1:0] tail_dst [NFIFO];
  logic [NFIFO-1:0]  tail_de, tail_de_n;

  // Queue side
  sinst_t           hd  [NFIFO];
  logic [CW-1:0]    cnt [NFIFO];
  logic [NFIFO-1:0] hvld, hrdy, gnt, push, empty, full;

  logic          l_hit, r_hit, st_ok, st_go;
  logic [FW-1:0] lf, rf, st_tgt;

  always_comb begin
    in_bus.id     = in_id;
    in_bus.dst_en = in_dst_en;
    in_bus.dst    = in_dst;
    in_bus.s0_en  = in_s0_en;
    in_bus.s0     = in_s0;
    in_bus.s1_en  = in_s1_en;
    in_bus.s1     = in_s1;
  end

  // Producer lookup: pending and still the tail of its queue
  always_comb begin
    lf    = pfifo[stg.s0];
    rf    = pfifo[stg.s1];
    l_hit = stg_vld && stg.s0_en && pend[stg.s0] && tail_de[lf] && (tail_dst[lf] == stg.s0);
    r_hit = stg_vld && stg.s1_en && pend[stg.s1] && tail_de[rf] && (tail_dst[rf] == stg.s1);
  end

  dsched_steer #(.NFIFO(NFIFO)) u_steer (
    .l_hit(l_hit), .l_fifo(lf), .r_hit(r_hit), .r_fifo(rf),
    .empty(empty), .full(full), .ok(st_ok), .tgt(st_tgt)
  );

  assign st_go  = stg_vld && st_ok;
  assign in_rdy = !stg_vld || st_ok;

  genvar f;
  generate
    for (f = 0; f < NFIFO; f++) begin : g_q
      assign push[f]  = st_go && (st_tgt == FW'(f));
      assign empty[f] = (cnt[f] == '0);
      assign full[f]  = (cnt[f] == CW'(DEPTH));
      assign hrdy[f]  = hvld[f] && (!hd[f].s0_en || reg_rdy[hd[f].s0])
                                && (!hd[f].s1_en || reg_rdy[hd[f].s1]);
      assign iss_id[f*ID_W +: ID_W] = hd[f].id;

      dsched_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_q_n), .push(push[f]), .din(stg),
        .pop(gnt[f]), .head(hd[f]), .hvld(hvld[f]), .cnt(cnt[f])
      );

      assert_table_clear_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
        (gnt[f] && hd[f].dst_en) |=> !pend[$past(hd[f].dst)]);
    end
  endgenerate

  dsched_arb #(.N(NFIFO), .LIMIT(ISSUE_W)) u_arb (.req(hrdy), .gnt(gnt));
  assign iss_vld = gnt;

  // Next state
  always_comb begin
    stg_vld_n = in_rdy ? in_vld : stg_vld;
    stg_n     = (in_rdy && in_vld) ? in_bus : stg;
    tail_de_n = tail_de;
    for (int q = 0; q < NFIFO; q++) begin
      if (push[q]) tail_de_n[q] = stg.dst_en;
    end
    pend_n = pend;
    for (int r = 0; r < NPREG; r++) begin
      for (int q = 0; q < NFIFO; q++) begin
        if (gnt[q] && hd[q].dst_en && (hd[q].dst == PTAG_W'(r))) pend_n[r] = 1'b0;
      end
      if (st_go && stg.dst_en && (stg.dst == PTAG_W'(r))) pend_n[r] = 1'b1;
    end
  end

  // Registers with reset
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      stg_vld <= 1'b0;
      pend    <= '0;
      tail_de <= '0;
    end else begin
      stg_vld <= stg_vld_n;
      pend    <= pend_n;
      tail_de <= tail_de_n;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (in_rdy && in_vld) stg <= stg_n;
    if (st_go && stg.dst_en) pfifo[stg.dst] <= st_tgt;
    for (int q = 0; q < NFIFO; q++) begin
      if (push[q]) tail_dst[q] <= stg.dst;
    end
  end

  assert_issue_limit_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(iss_vld) <= ISSUE_W);
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (stg_vld && !in_rdy) |=> (stg_vld && $stable(stg)));
endmodule

// File: tb/sim_dep_steer_sched.sv
module sim_dep_steer_sched;
  import dsched_pkg::*;
  localparam int CLK_P = 10;
  localparam int NF    = 4;
  localparam int IW    = ID_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_vld = 1'b0, in_rdy;
  logic [IW-1:0] in_id = '0;
  logic in_dst_en = 1'b0, in_s0_en = 1'b0, in_s1_en = 1'b0;
  logic [PTAG_W-1:0] in_dst = '0, in_s0 = '0, in_s1 = '0;
  logic [2**PTAG_W-1:0] reg_rdy;
  logic [NF-1:0] iss_vld;
  logic [NF*IW-1:0] iss_id;

  always #(CLK_P/2) clk = ~clk;

  dep_steer_sched #(.NFIFO(NF), .DEPTH(4), .ISSUE_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy), .in_id(in_id),
    .in_dst_en(in_dst_en), .in_dst(in_dst), .in_s0_en(in_s0_en), .in_s0(in_s0),
    .in_s1_en(in_s1_en), .in_s1(in_s1), .reg_rdy(reg_rdy),
    .iss_vld(iss_vld), .iss_id(iss_id)
  );

  typedef struct { int q; int id; string req; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic expect_iss(input int q, input int id, input string req);
    exp_t e;
    e.q = q; e.id = id; e.req = req;
    exp_q.push_back(e);
  endtask

  // Drive one instruction; returns just after the accepting edge
  task automatic send(input int id, input bit de, input int d,
                      input bit e0, input int s0, input bit e1, input int s1);
    @(posedge clk); #1;
    in_vld = 1'b1; in_id = IW'(id);
    in_dst_en = de; in_dst = PTAG_W'(d);
    in_s0_en = e0; in_s0 = PTAG_W'(s0);
    in_s1_en = e1; in_s1 = PTAG_W'(s1);
    forever begin
      @(negedge clk);
      if (in_rdy) begin
        @(posedge clk); #1;
        in_vld = 1'b0;
        break;
      end
    end
  endtask

  task automatic set_rdy(input int r, input bit v);
    @(posedge clk); #1;
    reg_rdy[r] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int q = 0; q < NF; q++) begin
        if (iss_vld[q]) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7", q, -1);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(q == e.q, e.req, q, e.q);
            check(int'(iss_id[q*IW +: IW]) == e.id, e.req, int'(iss_id[q*IW +: IW]), e.id);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    reg_rdy = '1;
    reg_rdy[31] = 1'b0;
    for (int r = 1; r <= 7; r++) reg_rdy[r] = 1'b0;
    reg_rdy[14] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    check(iss_vld == '0, "R1", int'(iss_vld), 0);
    check(in_rdy == 1'b1, "R1", int'(in_rdy), 1);

    // Fill queues with blocked chains (gate register 31 not ready)
    send(1, 1, 1, 1, 31, 0, 0);  // no pending source -> q0
    send(2, 1, 2, 1, 1, 0, 0);   // producer 1 is tail of q0 -> q0
    send(3, 1, 3, 1, 1, 0, 0);   // producer 1 not tail -> empty q1
    send(4, 1, 4, 1, 2, 1, 3);   // left 2 is tail of q0 -> q0
    send(5, 1, 5, 1, 9, 1, 3);   // left not pending, right 3 tail of q1 -> q1
    send(6, 0, 0, 1, 1, 1, 5);   // left not tail, right 5 tail of q1 -> q1
    send(7, 1, 7, 1, 1, 1, 3);   // neither tail -> empty q2
    send(8, 0, 0, 1, 31, 0, 0);  // -> q3
    send(9, 0, 0, 1, 31, 0, 0);  // nothing free -> stall
    @(negedge clk);
    check(in_rdy == 1'b0, "R6", int'(in_rdy), 0);
    idle(3);
    @(negedge clk);
    check(in_rdy == 1'b0, "R6", int'(in_rdy), 0);
    check(iss_vld == '0, "R7", int'(iss_vld), 0);

    expect_iss(0, 1, "R3");
    expect_iss(3, 8, "R3");
    expect_iss(3, 9, "R6");
    set_rdy(31, 1'b1);
    idle(6);
    check(exp_q.size() == 0, "R6", exp_q.size(), 0);

    // Wake three heads at once: limit of two, low queues first
    expect_iss(0, 2, "R4");
    expect_iss(1, 3, "R4");
    expect_iss(1, 5, "R5");
    expect_iss(2, 7, "R5");
    @(posedge clk); #1;
    reg_rdy[1] = 1'b1; reg_rdy[3] = 1'b1;
    @(negedge clk);
    check($countones(iss_vld) == 2, "R8", $countones(iss_vld), 2);
    check(iss_vld[2] == 1'b0, "R8", int'(iss_vld[2]), 0);
    idle(4);

    expect_iss(0, 4, "R5");
    expect_iss(1, 6, "R5");
    @(posedge clk); #1;
    reg_rdy[2] = 1'b1; reg_rdy[5] = 1'b1;
    idle(4);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);

    // Head blocking, latency, and producer table erase
    set_rdy(31, 1'b0);
    send(13, 1, 13, 1, 31, 0, 0);  // -> q0, blocked
    send(16, 0, 0, 1, 13, 0, 0);   // behind blocked head in q0, operand ready
    expect_iss(1, 14, "R2");
    send(14, 1, 14, 0, 0, 0, 0);   // -> q1, issues right away
    @(negedge clk);
    check(iss_vld == '0, "R2", int'(iss_vld), 0);
    @(negedge clk);
    check(iss_vld == 4'b0010, "R2", int'(iss_vld), 2);
    set_rdy(14, 1'b1);
    idle(3);
    @(negedge clk);
    check(iss_vld == '0, "R7", int'(iss_vld), 0);

    expect_iss(0, 13, "R7");
    expect_iss(0, 16, "R7");
    set_rdy(31, 1'b1);
    idle(4);
    expect_iss(0, 15, "R9");        // producer 14 gone -> lowest empty q0
    send(15, 0, 0, 1, 14, 0, 0);
    idle(5);
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);

    done = 1;
    finish_run();
  end
endmodule